// File: doc/BRIEF.md
# Fetch-to-Execute Instruction Handoff Interlock

This block couples an instruction-fetch engine to a separate execution engine. The fetch engine decodes each instruction and works out its effective address. It then offers the instruction here with a class code, the location of the operand it wants to read, and the location the instruction will eventually write. Instructions that only steer the program counter are retired on the spot: skips, jumps and tests. The block advances its own PC register for them, and nothing reaches the execution engine. All other instructions are latched into a single handoff stage. That stage holds the opcode with its accumulator field, the effective address and the instruction's own PC. The execution engine drains the stage through a valid/ready pair.

The fetch engine never stores results. Every store belongs to the execution engine, so the block tracks the destinations still owed. One is held by the instruction waiting in the handoff stage, and one by the instruction the execution engine is running. An operand read that matches either destination is refused until the execution engine reports the write as done. A class bit lets the fetch engine skip this comparison for instructions whose operands it knows the execution engine will not touch.

Top module: `fetch_exec_coupler`

## Requirements
- R1: With `rst` high at a rising edge, the handoff stage and both pending-write entries clear, and `fetch_pc` loads `reset_pc`. After reset `ex_valid` is 0 and an idle request sees `in_ready` high.
- R2: An accepted instruction whose `in_cls` bit 1 is 0 is forwarded. From the next cycle the handoff stage shows its `in_opcode`, `in_ac`, `in_ea` and the `fetch_pc` it was accepted at, and `fetch_pc` is one greater.
- R3: A transfer to the execution engine happens on a cycle with `ex_valid` and `ex_ready` both high. Once `ex_valid` is high it stays high, with `ex_opcode`, `ex_ac`, `ex_ea` and `ex_pc` unchanged, until that transfer.
- R4: A forwarded-class request is refused (`in_ready` low) while the handoff stage is occupied and is not transferring in the same cycle.
- R5: A request with `in_cls` bit 1 set is control-only. On acceptance it never enters the handoff stage. `fetch_pc` becomes `in_target` when `in_taken` is 1, and `fetch_pc`+1 otherwise.
- R6: When `in_src_en` is 1 and `in_cls` bit 0 is 0, `in_ready` is low if `in_src` equals a destination still owed. Owed destinations are the one held in the handoff stage (if `in_dst_en` was set for it) and the one being executed.
- R7: When `in_cls` bit 0 is 1, no conflict comparison is made. A control-only request with that bit set is always accepted, and a forwarded one waits only for the handoff stage.
- R8: The executing entry clears one cycle after `ex_wr_done`. While it is still owed, `ex_valid` is low unless `ex_wr_done` is high in the same cycle. `ex_wr_done` with no entry owed has no effect.
- R9: A control-only request whose operand conflicts waits exactly like a forwarded one: it is refused and `fetch_pc` does not move until the conflicting write is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_pc | input | EA_W | PC value loaded at reset |
| in_valid | input | 1 | Fetch engine offers a decoded instruction |
| in_ready | output | 1 | Offered instruction is accepted this cycle |
| in_cls | input | 2 | Bit 1: control-only; bit 0: skip conflict check |
| in_opcode | input | OPC_W | Instruction opcode |
| in_ac | input | AC_W | Accumulator field |
| in_ea | input | EA_W | Computed effective address |
| in_src_en | input | 1 | Instruction reads an operand location |
| in_src | input | EA_W | Operand location read |
| in_dst_en | input | 1 | Instruction will have a result written |
| in_dst | input | EA_W | Location the execution engine will write |
| in_taken | input | 1 | Control-only outcome: branch to target |
| in_target | input | EA_W | Next PC when taken |
| fetch_pc | output | EA_W | Current fetch program counter |
| ex_valid | output | 1 | Handoff stage offered to execution engine |
| ex_ready | input | 1 | Execution engine takes the handoff stage |
| ex_opcode | output | OPC_W | Handoff opcode |
| ex_ac | output | AC_W | Handoff accumulator field |
| ex_ea | output | EA_W | Handoff effective address |
| ex_pc | output | EA_W | PC of handed-off instruction |
| ex_wr_done | input | 1 | Execution engine finished the owed write |

## Verification
The bench builds the block with its default widths: a 9-bit opcode, a 4-bit accumulator field and 18-bit addresses. That lets it use small location numbers, and it puts PC values such as 300 and 500 in reach so that taken jumps and reset reloads stand apart from plain increments. A cycle-by-cycle vector table drives one instruction into a conflict with the handoff-stage destination and then with the executing destination, and releases it through a write-done strobe. The same table covers a control-only jump blocked by a conflict and the same jump passed by the check-suppress bit. Directed steps then check the handoff payload, a skip landing on PC+2 while the stage stays occupied, a reset in mid-run, and a write-done strobe that arrives with nothing owed.

// File: rtl/fx_pkg.sv
package fx_pkg;
  // Bit positions inside the instruction class code
  localparam int CLS_W         = 2;
  localparam int CLS_CTRL_BIT  = 1;  // retire locally, PC-only
  localparam int CLS_NOCHK_BIT = 0;  // conflict comparison suppressed
  // Number of owed-write entries tracked: handoff stage + executing
  localparam int PEND_N        = 2;
endpackage

// File: rtl/fx_hazard.sv
module fx_hazard #(
  parameter int LOC_W = 18,
  parameter int N     = 2
) (
  input  logic                      chk_en,
  input  logic [LOC_W-1:0]          loc,
  input  logic [N-1:0]              ent_v,
  input  logic [N-1:0][LOC_W-1:0]   ent_loc,
  output logic                      hit
);
  logic [N-1:0] cmp;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign cmp[g] = ent_v[g] && (ent_loc[g] == loc);
  end

  assign hit = chk_en && (|cmp);
endmodule

// File: rtl/fx_pending.sv
module fx_pending #(
  parameter int LOC_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_done,
  input  logic             xfer,
  input  logic             stage_dst_v,
  input  logic [LOC_W-1:0] stage_dst,
  output logic             run_v,
  output logic [LOC_W-1:0] run_dst
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run_v   <= 1'b0;
      run_dst <= '0;
    end else begin
      if (wr_done) run_v <= 1'b0;
      if (xfer) begin
        run_v   <= stage_dst_v;
        run_dst <= stage_dst;
      end
    end
  end
endmodule

// File: rtl/fx_stage.sv
module fx_stage #(
  parameter int OPC_W = 9,
  parameter int AC_W  = 4,
  parameter int LOC_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             xfer,
  input  logic [OPC_W-1:0] d_opcode,
  input  logic [AC_W-1:0]  d_ac,
  input  logic [LOC_W-1:0] d_ea,
  input  logic [LOC_W-1:0] d_pc,
  input  logic             d_dst_v,
  input  logic [LOC_W-1:0] d_dst,
  output logic             q_v,
  output logic [OPC_W-1:0] q_opcode,
  output logic [AC_W-1:0]  q_ac,
  output logic [LOC_W-1:0] q_ea,
  output logic [LOC_W-1:0] q_pc,
  output logic             q_dst_v,
  output logic [LOC_W-1:0] q_dst
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_v      <= 1'b0;
      q_opcode <= '0;
      q_ac     <= '0;
      q_ea     <= '0;
      q_pc     <= '0;
      q_dst_v  <= 1'b0;
      q_dst    <= '0;
    end else begin
      if (xfer) q_v <= 1'b0;
      if (load) begin
        q_v      <= 1'b1;
        q_opcode <= d_opcode;
        q_ac     <= d_ac;
        q_ea     <= d_ea;
        q_pc     <= d_pc;
        q_dst_v  <= d_dst_v;
        q_dst    <= d_dst;
      end
    end
  end
endmodule

// File: rtl/fx_pcunit.sv
module fx_pcunit #(
  parameter int LOC_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LOC_W-1:0] reset_pc,
  input  logic             adv,
  input  logic             jump,
  input  logic [LOC_W-1:0] target,
  output logic [LOC_W-1:0] pc
);
  localparam logic [LOC_W-1:0] ONE = LOC_W'(1);

  always_ff @(posedge clk) begin
    if (rst)       pc <= reset_pc;
    else if (jump) pc <= target;
    else if (adv)  pc <= pc + ONE;
  end
endmodule

// File: rtl/fetch_exec_coupler.sv
module fetch_exec_coupler
  import fx_pkg::*;
#(
  parameter int OPC_W = 9,
  parameter int AC_W  = 4,
  parameter int EA_W  = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EA_W-1:0]  reset_pc,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CLS_W-1:0] in_cls,
  input  logic [OPC_W-1:0] in_opcode,
  input  logic [AC_W-1:0]  in_ac,
  input  logic [EA_W-1:0]  in_ea,
  input  logic             in_src_en,
  input  logic [EA_W-1:0]  in_src,
  input  logic             in_dst_en,
  input  logic [EA_W-1:0]  in_dst,
  input  logic             in_taken,
  input  logic [EA_W-1:0]  in_target,
  output logic [EA_W-1:0]  fetch_pc,
  output logic             ex_valid,
  input  logic             ex_ready,
  output logic [OPC_W-1:0] ex_opcode,
  output logic [AC_W-1:0]  ex_ac,
  output logic [EA_W-1:0]  ex_ea,
  output logic [EA_W-1:0]  ex_pc,
  input  logic             ex_wr_done
);
  logic                           stage_v;
  logic                           stage_dst_v;
  logic [EA_W-1:0]                stage_dst;
  logic                           run_v;
  logic [EA_W-1:0]                run_dst;
  logic                           is_ctrl;
  logic                           no_chk;
  logic                           xfer;
  logic                           slot_free;
  logic                           hit;
  logic                           accept;
  logic                           load;
  logic [PEND_N-1:0]              ent_v;
  logic [PEND_N-1:0][EA_W-1:0]    ent_loc;

  assign is_ctrl = in_cls[CLS_CTRL_BIT];
  assign no_chk  = in_cls[CLS_NOCHK_BIT];

  // Stage is offered only once the executing write is retired (or retiring now)
  assign ex_valid  = stage_v && (!run_v || ex_wr_done);
  assign xfer      = ex_valid && ex_ready;
  assign slot_free = !stage_v || xfer;

  assign ent_v   = {stage_v && stage_dst_v, run_v};
  assign ent_loc = {stage_dst, run_dst};

  fx_hazard #(.LOC_W(EA_W), .N(PEND_N)) hz_i (
    .chk_en  (in_valid && in_src_en && !no_chk),
    .loc     (in_src),
    .ent_v   (ent_v),
    .ent_loc (ent_loc),
    .hit     (hit)
  );

  assign in_ready = !hit && (is_ctrl || slot_free);
  assign accept   = in_valid && in_ready;
  assign load     = accept && !is_ctrl;

  fx_stage #(.OPC_W(OPC_W), .AC_W(AC_W), .LOC_W(EA_W)) st_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .xfer     (xfer),
    .d_opcode (in_opcode),
    .d_ac     (in_ac),
    .d_ea     (in_ea),
    .d_pc     (fetch_pc),
    .d_dst_v  (in_dst_en),
    .d_dst    (in_dst),
    .q_v      (stage_v),
    .q_opcode (ex_opcode),
    .q_ac     (ex_ac),
    .q_ea     (ex_ea),
    .q_pc     (ex_pc),
    .q_dst_v  (stage_dst_v),
    .q_dst    (stage_dst)
  );

  fx_pending #(.LOC_W(EA_W)) pd_i (
    .clk         (clk),
    .rst         (rst),
    .wr_done     (ex_wr_done),
    .xfer        (xfer),
    .stage_dst_v (stage_dst_v),
    .stage_dst   (stage_dst),
    .run_v       (run_v),
    .run_dst     (run_dst)
  );

  fx_pcunit #(.LOC_W(EA_W)) pc_i (
    .clk      (clk),
    .rst      (rst),
    .reset_pc (reset_pc),
    .adv      (accept),
    .jump     (accept && is_ctrl && in_taken),
    .target   (in_target),
    .pc       (fetch_pc)
  );
endmodule

// File: rtl/fx_coupler_chk.sv
module fx_coupler_chk #(
  parameter int OPC_W = 9,
  parameter int AC_W  = 4,
  parameter int EA_W  = 18
) (
  input logic             clk,
  input logic             rst,
  input logic [EA_W-1:0]  reset_pc,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_cls,
  input logic [EA_W-1:0]  in_ea,
  input logic             in_src_en,
  input logic [EA_W-1:0]  in_src,
  input logic             in_taken,
  input logic [EA_W-1:0]  in_target,
  input logic [EA_W-1:0]  fetch_pc,
  input logic             ex_valid,
  input logic             ex_ready,
  input logic [OPC_W-1:0] ex_opcode,
  input logic [AC_W-1:0]  ex_ac,
  input logic [EA_W-1:0]  ex_ea,
  input logic [EA_W-1:0]  ex_pc,
  input logic             ex_wr_done,
  input logic             stage_v,
  input logic             run_v,
  input logic [EA_W-1:0]  run_dst
);
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!stage_v && !run_v && fetch_pc == $past(reset_pc)));

  p_forward_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_cls[1]) |=>
      (stage_v && ex_ea == $past(in_ea) && ex_pc == $past(fetch_pc)));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && !ex_ready) |=>
      (ex_valid && $stable(ex_opcode) && $stable(ex_ac) && $stable(ex_ea) && $stable(ex_pc)));

  p_full_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_cls[1] && stage_v && !(ex_valid && ex_ready)) |-> !in_ready);

  p_ctrl_local_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_cls[1] && !stage_v) |=> !stage_v);

  p_ctrl_jump_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_cls[1] && in_taken) |=> (fetch_pc == $past(in_target)));

  p_conflict_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_cls[0] && in_src_en && run_v && in_src == run_dst) |-> !in_ready);

  p_nochk_ctrl_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls[1] && in_cls[0]) |-> in_ready);

  p_done_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (run_v && ex_wr_done && !(ex_valid && ex_ready)) |=> !run_v);

  p_offer_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (run_v && !ex_wr_done) |-> !ex_valid);

  p_ctrl_wait_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls[1] && !in_ready) |=> $stable(fetch_pc));
endmodule

bind fetch_exec_coupler fx_coupler_chk #(
  .OPC_W(OPC_W), .AC_W(AC_W), .EA_W(EA_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .reset_pc   (reset_pc),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_cls     (in_cls),
  .in_ea      (in_ea),
  .in_src_en  (in_src_en),
  .in_src     (in_src),
  .in_taken   (in_taken),
  .in_target  (in_target),
  .fetch_pc   (fetch_pc),
  .ex_valid   (ex_valid),
  .ex_ready   (ex_ready),
  .ex_opcode  (ex_opcode),
  .ex_ac      (ex_ac),
  .ex_ea      (ex_ea),
  .ex_pc      (ex_pc),
  .ex_wr_done (ex_wr_done),
  .stage_v    (stage_v),
  .run_v      (run_v),
  .run_dst    (run_dst)
);

// File: tb/fetch_exec_coupler_tb_top.sv
module fetch_exec_coupler_tb_top;
  localparam int OPC_W = 9;
  localparam int AC_W  = 4;
  localparam int EA_W  = 18;

  logic             clk = 1'b0;
  logic             rst;
  logic [EA_W-1:0]  reset_pc;
  logic             in_valid;
  logic             in_ready;
  logic [1:0]       in_cls;
  logic [OPC_W-1:0] in_opcode;
  logic [AC_W-1:0]  in_ac;
  logic [EA_W-1:0]  in_ea;
  logic             in_src_en;
  logic [EA_W-1:0]  in_src;
  logic             in_dst_en;
  logic [EA_W-1:0]  in_dst;
  logic             in_taken;
  logic [EA_W-1:0]  in_target;
  logic [EA_W-1:0]  fetch_pc;
  logic             ex_valid;
  logic             ex_ready;
  logic [OPC_W-1:0] ex_opcode;
  logic [AC_W-1:0]  ex_ac;
  logic [EA_W-1:0]  ex_ea;
  logic [EA_W-1:0]  ex_pc;
  logic             ex_wr_done;

  always #2.5 clk = ~clk;  // 200 MHz

  fetch_exec_coupler #(.OPC_W(OPC_W), .AC_W(AC_W), .EA_W(EA_W)) dut_i (.*);

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One row per cycle: inputs, then outputs expected before the edge
  typedef struct packed {
    logic        v;
    logic [1:0]  cls;
    logic        src_en;
    logic [17:0] src;
    logic        dst_en;
    logic [17:0] dst;
    logic [17:0] ea;
    logic        taken;
    logic [17:0] tgt;
    logic        rdy;
    logic        wd;
    logic        e_rdy;
    logic        e_val;
    logic [17:0] e_ea;
    logic [17:0] e_pc;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    // v cls se src de dst ea tk tgt rdy wd | in_rdy ex_val ex_ea pc
    '{1'b1, 2'd0, 1'b0, 18'd0, 1'b1, 18'd5, 18'd20, 1'b0, 18'd0, 1'b0, 1'b0, 1'b1, 1'b0, 18'd0,  18'd100}, // R2 accept
    '{1'b1, 2'd0, 1'b1, 18'd5, 1'b1, 18'd6, 18'd21, 1'b0, 18'd0, 1'b0, 1'b0, 1'b0, 1'b1, 18'd20, 18'd101}, // R6 stage dst
    '{1'b1, 2'd0, 1'b1, 18'd5, 1'b1, 18'd6, 18'd21, 1'b0, 18'd0, 1'b1, 1'b0, 1'b0, 1'b1, 18'd20, 18'd101}, // R3 xfer
    '{1'b1, 2'd0, 1'b1, 18'd5, 1'b1, 18'd6, 18'd21, 1'b0, 18'd0, 1'b1, 1'b0, 1'b0, 1'b0, 18'd0,  18'd101}, // R6 run dst
    '{1'b1, 2'd0, 1'b1, 18'd5, 1'b1, 18'd6, 18'd21, 1'b0, 18'd0, 1'b1, 1'b1, 1'b0, 1'b0, 18'd0,  18'd101}, // R8 done
    '{1'b1, 2'd0, 1'b1, 18'd5, 1'b1, 18'd6, 18'd21, 1'b0, 18'd0, 1'b1, 1'b0, 1'b1, 1'b0, 18'd0,  18'd101}, // R6 released
    '{1'b1, 2'd2, 1'b1, 18'd6, 1'b0, 18'd0, 18'd0,  1'b1, 18'd300, 1'b0, 1'b0, 1'b0, 1'b1, 18'd21, 18'd102}, // R9 ctrl wait
    '{1'b1, 2'd3, 1'b1, 18'd6, 1'b0, 18'd0, 18'd0,  1'b1, 18'd300, 1'b0, 1'b0, 1'b1, 1'b1, 18'd21, 18'd102}, // R7 nochk ctrl
    '{1'b1, 2'd1, 1'b1, 18'd6, 1'b1, 18'd7, 18'd22, 1'b0, 18'd0, 1'b0, 1'b0, 1'b0, 1'b1, 18'd21, 18'd300}, // R4 full
    '{1'b1, 2'd1, 1'b1, 18'd6, 1'b1, 18'd7, 18'd22, 1'b0, 18'd0, 1'b1, 1'b0, 1'b1, 1'b1, 18'd21, 18'd300}, // R7 nochk fwd
    '{1'b1, 2'd2, 1'b1, 18'd9, 1'b0, 18'd0, 18'd0,  1'b0, 18'd0, 1'b1, 1'b0, 1'b1, 1'b0, 18'd0,  18'd301}, // R8 gate, R5
    '{1'b0, 2'd0, 1'b0, 18'd0, 1'b0, 18'd0, 18'd0,  1'b0, 18'd0, 1'b1, 1'b1, 1'b1, 1'b1, 18'd22, 18'd302}, // R8 same-cycle
    '{1'b0, 2'd0, 1'b0, 18'd0, 1'b0, 18'd0, 18'd0,  1'b0, 18'd0, 1'b0, 1'b0, 1'b1, 1'b0, 18'd0,  18'd302}  // R3 drained
  };

  task automatic idle();
    in_valid = 1'b0; in_cls = 2'd0; in_opcode = '0; in_ac = '0; in_ea = '0;
    in_src_en = 1'b0; in_src = '0; in_dst_en = 1'b0; in_dst = '0;
    in_taken = 1'b0; in_target = '0; ex_ready = 1'b0; ex_wr_done = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    idle();
    rst = 1'b1; reset_pc = 18'd100;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 reset pc", 32'(fetch_pc), 32'd100);
    chk("R1 reset ex_valid", 32'(ex_valid), 32'd0);
    chk("R1 reset in_ready", 32'(in_ready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = TBL[i].v; in_cls = TBL[i].cls; in_src_en = TBL[i].src_en;
      in_src = TBL[i].src; in_dst_en = TBL[i].dst_en; in_dst = TBL[i].dst;
      in_ea = TBL[i].ea; in_taken = TBL[i].taken; in_target = TBL[i].tgt;
      ex_ready = TBL[i].rdy; ex_wr_done = TBL[i].wd;
      in_opcode = 9'(i); in_ac = 4'(i);
      #1;
      chk($sformatf("R6/R4 row%0d in_ready", i), 32'(in_ready), 32'(TBL[i].e_rdy));
      chk($sformatf("R3/R8 row%0d ex_valid", i), 32'(ex_valid), 32'(TBL[i].e_val));
      chk($sformatf("R5/R2 row%0d pc", i), 32'(fetch_pc), 32'(TBL[i].e_pc));
      if (TBL[i].e_val)
        chk($sformatf("R2 row%0d ex_ea", i), 32'(ex_ea), 32'(TBL[i].e_ea));
    end

    // R2 payload: stage empty, executing entry (dst 7) still owed
    @(negedge clk); idle();
    in_valid = 1'b1; in_opcode = 9'h1A3; in_ac = 4'd7; in_ea = 18'd55;
    @(negedge clk); idle(); #1;
    chk("R2 ex_opcode", 32'(ex_opcode), 32'h1A3);
    chk("R2 ex_ac", 32'(ex_ac), 32'd7);
    chk("R2 ex_ea", 32'(ex_ea), 32'd55);
    chk("R2 ex_pc", 32'(ex_pc), 32'd302);
    chk("R2 pc step", 32'(fetch_pc), 32'd303);
    chk("R8 not offered while owed", 32'(ex_valid), 32'd0);
    ex_wr_done = 1'b1; #1;
    chk("R8 offered with done", 32'(ex_valid), 32'd1);
    @(negedge clk); idle(); #1;
    chk("R3 still valid", 32'(ex_valid), 32'd1);
    // R5 skip on control-only path, stage untouched
    in_valid = 1'b1; in_cls = 2'd3; in_taken = 1'b1; in_target = 18'd305;
    @(negedge clk); idle(); #1;
    chk("R5 skip pc", 32'(fetch_pc), 32'd305);
    chk("R5 stage payload kept", 32'(ex_ea), 32'd55);
    chk("R5 stage pc kept", 32'(ex_pc), 32'd302);
    // R5 not-taken control-only
    in_valid = 1'b1; in_cls = 2'd2;
    @(negedge clk); idle(); #1;
    chk("R5 not taken pc", 32'(fetch_pc), 32'd306);

    // R1 reset in mid-run
    rst = 1'b1; reset_pc = 18'd500;
    @(negedge clk); rst = 1'b0; #1;
    chk("R1 mid reset pc", 32'(fetch_pc), 32'd500);
    chk("R1 mid reset ex_valid", 32'(ex_valid), 32'd0);

    // R8 stray done ignored; nothing owed so a checked read goes through
    ex_wr_done = 1'b1;
    @(negedge clk); idle();
    in_valid = 1'b1; in_src_en = 1'b1; in_src = 18'd7; #1;
    chk("R8 stray done in_ready", 32'(in_ready), 32'd1);
    @(negedge clk); idle(); #1;
    chk("R8 stray done no offer glitch", 32'(ex_valid), 32'd1);
    chk("R2 pc after", 32'(fetch_pc), 32'd501);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule